// File: doc/BRIEF.md
# Selectable-Ratio Controller Clock Divider

This block produces a controller clock from a fast source clock. A 3-bit ratio code chooses one of eight division factors from an irregular set. The output can be switched off with an enable control, or replaced by an alternate clock taken from an external pin.

The divider has its own synchronous hold control. Software raises it, writes the new ratio code, reads the code and the enable back to confirm them, and then lowers it. The ratio code is taken in only while the hold is raised, so a code change during normal running cannot produce a short pulse.

A constant output reports the code that suits the configured source frequency. It is the smallest ratio whose result falls in the 150 MHz to 300 MHz window, with both ends counted as inside.

Top module: `ctlclk_div`

## Requirements
- R1: Ratio code 0, 1, 2, 3, 4, 5, 6 and 7 divides the source clock by 1, 2, 4, 6, 8, 16, 24 and 32 respectively. Over 96 source cycles `clk_o` shows 96/ratio rising edges.
- R2: For every ratio of 2 or more, the output is high for exactly half of each period. It toggles every ratio/2 source cycles.
- R3: While `div_rst_i` is high, the internal path of `clk_o` is held low and the phase counter is cleared. After release with ratio 8, `clk_o` stays low at the first three source edges and rises at the fourth.
- R4: A change of `sel_i` while `div_rst_i` is low has no effect on the active ratio or on `sel_o` until the next time `div_rst_i` is high.
- R5: `sel_o` returns the active ratio code, which follows `sel_i` one cycle after a clock edge where `div_rst_i` is high. `en_o` returns `en_i` one cycle later.
- R6: When the registered enable is 0, `clk_o` shows no rising edge, whichever path is selected.
- R7: When the registered bypass select is 1, `clk_o` follows `alt_clk_i`. When it is 0, `clk_o` carries the divided source clock. The select is registered on the source clock.
- R8: `auto_sel_o` is the lowest code whose ratio brings `SRC_HZ` into the range 150 MHz to 300 MHz inclusive. `auto_ok_o` is 1 when such a code exists.
- R9: With code 0 the source clock passes straight through, gated on a falling-edge enable so that the pulses are whole.
- R10: After the global reset, `sel_o` is 0, `en_o` is 0 and `clk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous active-low global reset |
| div_rst_i | input | 1 | Divider hold; ratio code is loaded while high |
| sel_i | input | 3 | Requested ratio code |
| en_i | input | 1 | Output clock enable |
| byp_i | input | 1 | 1 selects the alternate pin clock |
| alt_clk_i | input | 1 | Alternate clock from a pin |
| clk_o | output | 1 | Controller clock |
| sel_o | output | 3 | Active ratio code readback |
| en_o | output | 1 | Registered enable readback |
| auto_sel_o | output | 3 | Suggested code for SRC_HZ |
| auto_ok_o | output | 1 | Suggested code is valid |

## Verification
On every cycle the assertions check several relations. The counter and toggle are cleared while the hold is high. The active code is frozen while the hold is low and follows the request while it is high. The enable readback tracks its input. The phase counter stays below half the active ratio, and the toggle only flips when the counter reaches its last value. The scenarios are needed for the properties that depend on frequency and phase: edge counts and duty per ratio, the first edge after release, the falling-edge gating of divide-by-1, and routing of the unrelated alternate clock. Only they can show these at the output pin.

// File: rtl/ckd_pkg.sv
package ckd_pkg;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned MAX_RATIO = 32;
  localparam int unsigned HALF_W    = $clog2(MAX_RATIO / 2) + 1;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO / 2);

  function automatic int unsigned ratio_of(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    ratio_of = 1;
      3'd1:    ratio_of = 2;
      3'd2:    ratio_of = 4;
      3'd3:    ratio_of = 6;
      3'd4:    ratio_of = 8;
      3'd5:    ratio_of = 16;
      3'd6:    ratio_of = 24;
      default: ratio_of = 32;
    endcase
  endfunction

  function automatic logic [HALF_W-1:0] half_of(input logic [CODE_W-1:0] code);
    int unsigned h;
    h = ratio_of(code) / 2;
    half_of = h[HALF_W-1:0];
  endfunction

  // returns {ok, code}: lowest ratio that lands inside [lo, hi]
  function automatic logic [CODE_W:0] pick_code(input longint unsigned src,
                                                input longint unsigned lo,
                                                input longint unsigned hi);
    logic [CODE_W:0] res;
    res = '0;
    for (int i = (1 << CODE_W) - 1; i >= 0; i--) begin
      longint unsigned f;
      f = src / longint'(ratio_of(i[CODE_W-1:0]));
      if (f >= lo && f <= hi) res = {1'b1, i[CODE_W-1:0]};
    end
    pick_code = res;
  endfunction
endpackage

// File: rtl/ckd_cfg.sv
module ckd_cfg
  import ckd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_rst_i,
  input  logic [CODE_W-1:0] sel_i,
  input  logic              en_i,
  input  logic              byp_i,
  output logic [CODE_W-1:0] sel_q,
  output logic              en_q,
  output logic              byp_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_q  <= 1'b0;
      byp_q <= 1'b0;
    end else begin
      if (div_rst_i) sel_q <= sel_i;
      en_q  <= en_i;
      byp_q <= byp_i;
    end
  end
endmodule

// File: rtl/ckd_core.sv
module ckd_core
  import ckd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_rst_i,
  input  logic [CODE_W-1:0] sel_q,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              tgl_o,
  output logic              wrap_o
);
  logic [HALF_W-1:0] half;
  logic [HALF_W-1:0] last;
  logic [CNT_W-1:0]  cnt_q;
  logic              tgl_q;

  assign half   = half_of(sel_q);
  assign last   = half - HALF_W'(1);
  assign wrap_o = (half != '0) && ({1'b0, cnt_q} == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else if (div_rst_i || half == '0) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else if (wrap_o) begin
      cnt_q <= '0;
      tgl_q <= ~tgl_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign tgl_o = tgl_q;
endmodule

// File: rtl/ckd_omux.sv
module ckd_omux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alt_clk_i,
  input  logic div_rst_i,
  input  logic pass_i,
  input  logic en_q,
  input  logic byp_q,
  input  logic tgl_i,
  output logic clk_o
);
  logic gate_nq;
  logic int_clk;

  // falling-edge gate keeps whole pulses on the pass-through path
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_nq <= 1'b0;
    else         gate_nq <= en_q & ~div_rst_i;
  end

  always_comb begin
    if (pass_i) int_clk = clk_i & gate_nq;
    else        int_clk = tgl_i & en_q;
    clk_o = byp_q ? (alt_clk_i & en_q) : int_clk;
  end
endmodule

// File: rtl/ctlclk_div.sv
module ctlclk_div
  import ckd_pkg::*;
#(
  parameter longint unsigned SRC_HZ = 64'd1_000_000_000,
  parameter longint unsigned LO_HZ  = 64'd150_000_000,
  parameter longint unsigned HI_HZ  = 64'd300_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_rst_i,
  input  logic [CODE_W-1:0] sel_i,
  input  logic              en_i,
  input  logic              byp_i,
  input  logic              alt_clk_i,
  output logic              clk_o,
  output logic [CODE_W-1:0] sel_o,
  output logic              en_o,
  output logic [CODE_W-1:0] auto_sel_o,
  output logic              auto_ok_o
);
  localparam logic [CODE_W:0] AUTO = pick_code(SRC_HZ, LO_HZ, HI_HZ);

  logic [CODE_W-1:0] sel_q;
  logic              en_q;
  logic              byp_q;
  logic [CNT_W-1:0]  cnt_w;
  logic              tgl_w;
  logic              wrap_w;

  ckd_cfg u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_rst_i(div_rst_i),
    .sel_i(sel_i), .en_i(en_i), .byp_i(byp_i),
    .sel_q(sel_q), .en_q(en_q), .byp_q(byp_q)
  );

  ckd_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_rst_i(div_rst_i), .sel_q(sel_q),
    .cnt_o(cnt_w), .tgl_o(tgl_w), .wrap_o(wrap_w)
  );

  ckd_omux u_omux (
    .clk_i(clk_i), .rst_ni(rst_ni), .alt_clk_i(alt_clk_i),
    .div_rst_i(div_rst_i), .pass_i(sel_q == '0), .en_q(en_q),
    .byp_q(byp_q), .tgl_i(tgl_w), .clk_o(clk_o)
  );

  assign sel_o      = sel_q;
  assign en_o       = en_q;
  assign auto_sel_o = AUTO[CODE_W-1:0];
  assign auto_ok_o  = AUTO[CODE_W];
endmodule

// File: rtl/ctlclk_div_chk.sv
module ctlclk_div_chk
  import ckd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              div_rst_i,
  input logic [CODE_W-1:0] sel_i,
  input logic              en_i,
  input logic [CODE_W-1:0] sel_o,
  input logic              en_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              tgl_i,
  input logic              wrap_i
);
  logic [HALF_W-1:0] half_w;
  assign half_w = half_of(sel_o);

  p_clear_in_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_rst_i |=> (cnt_i == '0 && !tgl_i));

  p_sel_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_rst_i |=> $stable(sel_o));

  p_sel_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_rst_i |=> (sel_o == $past(sel_i)));

  p_en_track_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !en_o);

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != '0) |-> ({1'b0, cnt_i} < half_w));

  p_pass_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == '0) |=> (cnt_i == '0 && !tgl_i));

  p_toggle_at_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!div_rst_i && !wrap_i && sel_o != '0) |=> $stable(tgl_i));
endmodule

bind ctlclk_div ctlclk_div_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .div_rst_i(div_rst_i), .sel_i(sel_i),
  .en_i(en_i), .sel_o(sel_o), .en_o(en_o), .cnt_i(cnt_w), .tgl_i(tgl_w),
  .wrap_i(wrap_w)
);

// File: tb/ctlclk_div_tb_top.sv
module ctlclk_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_rst = 1'b1;
  logic [2:0] sel = 3'd0;
  logic       en = 1'b0;
  logic       byp = 1'b0;
  logic       alt = 1'b0;
  logic       clk_o;
  logic [2:0] sel_o;
  logic       en_o;
  logic [2:0] auto_sel;
  logic       auto_ok;

  int errors = 0;
  int checks = 0;
  int edges  = 0;
  bit counting = 1'b0;

  always #4 clk = ~clk;
  initial begin
    #3;
    forever #8 alt = ~alt;
  end

  always @(posedge clk_o) if (counting) edges++;

  ctlclk_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_rst_i(div_rst), .sel_i(sel),
    .en_i(en), .byp_i(byp), .alt_clk_i(alt), .clk_o(clk_o),
    .sel_o(sel_o), .en_o(en_o), .auto_sel_o(auto_sel), .auto_ok_o(auto_ok)
  );

  function automatic int ratio_tb(input int code);
    int tbl [8] = '{1, 2, 4, 6, 8, 16, 24, 32};
    return tbl[code];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic measure(output int e, output int h);
    @(posedge clk); #2;
    edges = 0; counting = 1'b1; h = 0;
    repeat (96) begin
      h += int'(clk_o);
      @(posedge clk); #2;
    end
    counting = 1'b0;
    e = edges;
  endtask

  task automatic program_code(input int code);
    div_rst = 1'b1; sel = 3'(code);
    step(2);
    check("R5 sel readback", int'(sel_o), code);
    div_rst = 1'b0;
    step(3);
  endtask

  task automatic t_reset_state();
    check("R10 sel after reset", int'(sel_o), 0);
    check("R10 en after reset", int'(en_o), 0);
    check("R10 clk low", int'(clk_o), 0);
  endtask

  task automatic t_ratios();
    for (int c = 0; c < 8; c++) begin
      int e, h, r;
      program_code(c);
      measure(e, h);
      r = ratio_tb(c);
      check($sformatf("R1 edges code %0d", c), e, 96 / r);
      if (c == 0) check("R9 passthrough high samples", h, 96);
      else        check($sformatf("R2 duty code %0d", c), h, 48);
    end
  endtask

  task automatic t_hold();
    int e, h;
    div_rst = 1'b1; sel = 3'd0;
    step(2);
    measure(e, h);
    check("R3 no edges in hold", e, 0);
    check("R3 low in hold", h, 0);
    sel = 3'd4;
    step(2);
    div_rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      check($sformatf("R3 low after release edge %0d", k), int'(clk_o), 0);
    end
    @(posedge clk); #2;
    check("R3 first rise at fourth edge", int'(clk_o), 1);
    #1;
  endtask

  task automatic t_ignore();
    int e, h;
    program_code(3);
    sel = 3'd0;
    step(3);
    check("R4 sel_o unchanged", int'(sel_o), 3);
    measure(e, h);
    check("R4 ratio kept at 6", e, 16);
    sel = 3'd7;
    step(2);
    check("R4 sel_o still 3", int'(sel_o), 3);
  endtask

  task automatic t_enable();
    int e, h;
    program_code(1);
    en = 1'b0;
    step(2);
    check("R5 en readback 0", int'(en_o), 0);
    measure(e, h);
    check("R6 no edges when disabled", e, 0);
    program_code(0);
    measure(e, h);
    check("R6 no edges passthrough disabled", e, 0);
    byp = 1'b1;
    step(2);
    measure(e, h);
    check("R6 no edges bypass disabled", e, 0);
    byp = 1'b0; en = 1'b1;
    step(2);
    check("R5 en readback 1", int'(en_o), 1);
  endtask

  task automatic t_bypass();
    int e, h;
    program_code(5);
    byp = 1'b1;
    step(2);
    measure(e, h);
    check("R7 alt clock edges", e, 48);
    byp = 1'b0;
    step(2);
    measure(e, h);
    check("R7 back to divided", e, 6);
  endtask

  task automatic t_auto();
    int exp = -1;
    longint src = 64'd1_000_000_000;
    for (int c = 7; c >= 0; c--) begin
      longint f = src / ratio_tb(c);
      if (f >= 150_000_000 && f <= 300_000_000) exp = c;
    end
    check("R8 auto ok", int'(auto_ok), 1);
    check("R8 auto code", int'(auto_sel), exp);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    t_reset_state();
    rst_n = 1'b1;
    step(2);
    t_reset_state();
    en = 1'b1;
    step(2);
    t_ratios();
    t_hold();
    t_ignore();
    t_enable();
    t_bypass();
    t_auto();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule